// File: doc/BRIEF.md
# Down-Counting Interval Timer

A 32-bit peripheral timer that a processor drives through three word registers on a simple write/read bus. The count clock is derived from the block clock by a programmable power-of-two prescaler. Once clocked and started, the counter steps down by one per count tick. When it finds itself at zero it emits a one-clock interrupt pulse. It then either reloads from the stored load value and carries on, or stops and holds at zero.

Typical uses are a periodic system tick, where auto-reload is set and the load value is the period minus one, and a single delayed event with auto-reload clear. A third use is a free-running clock source: load all ones with auto-reload set, and the bitwise inverse of the count gives the ticks elapsed since the start.

Top module: `cdt_top`

## Requirements
- R1: After synchronous reset, the control register and the count read back as zero and `irq` is low.
- R2: The registers are word-aligned at byte offsets 0x0 (control), 0x4 (load) and 0x8 (count). Control bit 0 is clock enable, bit 1 is run, bit 2 is auto-reload and bits 5:3 are the prescale code P, and control reads back these six bits. Load reads as zero. Writes to count or to misaligned addresses are ignored.
- R3: While clock enable is 1, a count tick occurs once every 2^(P+1) clocks, so P=0 ticks every second clock.
- R4: A write that changes run from 0 to 1 makes the next tick copy the load value into the counter. Each later tick while running lowers the count by one.
- R5: A tick that finds a running count at zero is an expiry, and `irq` is high for exactly the one clock after the expiry edge.
- R6: With auto-reload set, an expiry reloads the load value, so the interrupt period is (load+1) ticks.
- R7: With auto-reload clear, an expiry clears the run bit and the count stays at zero.
- R8: Clearing run stops the counter, and the count holds its current value.
- R9: Changing only the auto-reload bit while running does not disturb the count.
- R10: While clock enable is 0, the prescaler and the counter are frozen.
- R11: A load write while run is 0 is copied into the counter on the next tick. A load write while running takes effect only at the next reload.
- R12: Loading all ones with auto-reload set gives a free-running counter whose bitwise inverse equals the ticks elapsed after the first load tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the prescaler reference |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | One-clock expiry pulse |

## Verification
A register write takes effect at the rising edge that samples it, and read data is combinational, so a read reflects every edge up to the sample point. Count ticks fall on every 2^(P+1)-th edge after the write that enables the clock from reset. The first tick after a start loads the counter, and the expiry edge comes (load+1) ticks after that. The interrupt is visible in the clock that follows the expiry edge. The bench records the edge index of each write, computes each due interrupt edge and live count from those indices, and has a monitor compare every observed pulse against a queue of due edges.

// File: rtl/cdt_pkg.sv
// cdt_pkg: shared constants and the control-register layout for the
// down-counting timer. Assumes a 32-bit bus with word-aligned registers.
package cdt_pkg;
    localparam int PS_W      = 3;        // prescale code width
    localparam int CTL_W     = PS_W + 3; // implemented control bits
    localparam int WORD_LSB  = 2;        // byte-to-word address shift

    localparam int IDX_CTRL  = 0;
    localparam int IDX_LOAD  = 1;
    localparam int IDX_COUNT = 2;

    // Packed from msb: prescale[5:3], auto-reload[2], run[1], enable[0]
    typedef struct packed {
        logic [PS_W-1:0] ps;
        logic            ar;
        logic            run;
        logic            en;
    } ctl_t;
endpackage

// File: rtl/cdt_prescale.sv
// cdt_prescale: divides the block clock by 2^(ps+1) into a one-clock
// tick. Assumes ps may change at any time; an over-range phase wraps at once.
module cdt_prescale #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [PS_W-1:0] ps,
    output logic            tick
);
    localparam int DIV_W = 1 << PS_W;

    logic [DIV_W-1:0] phase;
    logic [DIV_W:0]   limit;

    // Terminal phase for the current prescale code
    always_comb begin
        limit = ((DIV_W+1)'(1) << (int'(ps) + 1)) - (DIV_W+1)'(1);
        tick  = en && ({1'b0, phase} >= limit);
    end

    // Phase counter advances only while enabled, otherwise frozen
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (en)
            phase <= tick ? '0 : phase + DIV_W'(1);
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R3
endmodule

// File: rtl/cdt_core.sv
// cdt_core: the down counter with pending-load flag, expiry detection and
// interrupt pulse. Assumes tick is a single-clock strobe and that run_set and
// load_idle are single-clock strobes from the register block.
module cdt_core #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              run,
    input  logic              ar,
    input  logic [DATA_W-1:0] load_val,
    input  logic              run_set,
    input  logic              load_idle,
    output logic [DATA_W-1:0] cnt,
    output logic              stop_req,
    output logic              irq
);
    logic pend;
    logic expire;

    // Expiry: a running count found at zero with no load pending
    always_comb begin
        expire   = tick && !pend && run && (cnt == '0);
        stop_req = expire && !ar;
    end

    // Pending-load flag: set by a start edge or an idle load write
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= 1'b0;
        else if (run_set || load_idle)
            pend <= 1'b1;
        else if (tick)
            pend <= 1'b0;
    end

    // Counter: load, decrement, reload or hold on each tick
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (tick) begin
            if (pend)
                cnt <= load_val;
            else if (run) begin
                if (cnt != '0)
                    cnt <= cnt - DATA_W'(1);
                else if (ar)
                    cnt <= load_val;
            end
        end
    end

    // Interrupt pulse registered one clock after expiry
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= expire;
    end

    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && !pend && cnt != '0) |=> cnt == $past(cnt) - DATA_W'(1)); // R4
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R5
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && ar) |=> cnt == $past(load_val)); // R6
    AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !pend) |=> $stable(cnt)); // R8
endmodule

// File: rtl/cdt_regs.sv
// cdt_regs: register decode, control and load storage, read mux. Assumes
// single-cycle writes and a combinational read; misaligned accesses miss.
module cdt_regs
    import cdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              stop_req,
    input  logic [DATA_W-1:0] cnt,
    output ctl_t              ctl,
    output logic [DATA_W-1:0] load_val,
    output logic              run_set,
    output logic              load_idle,
    output logic [DATA_W-1:0] rdata
);
    localparam int IDX_W = ADDR_W - WORD_LSB;

    logic [IDX_W-1:0] idx;
    logic             aligned;
    logic             wr_ctrl;
    logic             wr_load;
    ctl_t             wctl;

    // Address decode and write strobes
    always_comb begin
        idx       = addr[ADDR_W-1:WORD_LSB];
        aligned   = (addr[WORD_LSB-1:0] == '0);
        wr_ctrl   = we && aligned && (idx == IDX_W'(IDX_CTRL));
        wr_load   = we && aligned && (idx == IDX_W'(IDX_LOAD));
        wctl      = ctl_t'(wdata[CTL_W-1:0]);
        run_set   = wr_ctrl && wctl.run && !ctl.run;
        load_idle = wr_load && !ctl.run;
    end

    // Control register: hardware stop, software write wins
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl <= '0;
        else begin
            if (stop_req)
                ctl.run <= 1'b0;
            if (wr_ctrl)
                ctl <= wctl;
        end
    end

    // Load register, write only
    always_ff @(posedge clk) begin
        if (!rst_n)
            load_val <= '0;
        else if (wr_load)
            load_val <= wdata;
    end

    // Read mux: control, zero for load, live count
    always_comb begin
        rdata = '0;
        if (aligned) begin
            if (idx == IDX_W'(IDX_CTRL))
                rdata = DATA_W'(ctl);
            else if (idx == IDX_W'(IDX_COUNT))
                rdata = cnt;
        end
    end

    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && !wr_ctrl) |=> !ctl.run); // R7
endmodule

// File: rtl/cdt_top.sv
// cdt_top: down-counting interval timer with register bus and interrupt.
// Assumes one clock domain; the prescaler reference is clk itself.
module cdt_top
    import cdt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    ctl_t              ctl;
    logic [DATA_W-1:0] load_val;
    logic [DATA_W-1:0] cnt;
    logic              run_set;
    logic              load_idle;
    logic              stop_req;
    logic              tick;

    cdt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we),
        .wdata(bus_wdata), .stop_req(stop_req), .cnt(cnt), .ctl(ctl),
        .load_val(load_val), .run_set(run_set), .load_idle(load_idle),
        .rdata(bus_rdata)
    );

    cdt_prescale #(.PS_W(PS_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(ctl.en), .ps(ctl.ps), .tick(tick)
    );

    cdt_core #(.DATA_W(DATA_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(ctl.run), .ar(ctl.ar),
        .load_val(load_val), .run_set(run_set), .load_idle(load_idle),
        .cnt(cnt), .stop_req(stop_req), .irq(irq)
    );

    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.en |=> $stable(cnt)); // R10
endmodule

// File: tb/cdt_top_test.sv
module cdt_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;
    int    exp_q[$];
    string tag_q[$];

    localparam logic [3:0] A_CTRL = 4'h0, A_LOAD = 4'h4, A_CNT = 4'h8;

    cdt_top uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
                 .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver side of the scoreboard: expected interrupt edges
    task automatic expect_irq(input int edge_idx, input string req);
        exp_q.push_back(edge_idx);
        tag_q.push_back(req);
    endtask

    // monitor: every pulse must match the head of the queue
    always @(negedge clk) begin
        if (rst_n && irq) begin
            if (exp_q.size() == 0)
                check(0, "R5 unexpected irq", cyc, 0);
            else begin
                automatic int e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(cyc == e, t, cyc, e);
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, output int w);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        w = cyc + 1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d, output int c);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
        c = cyc;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // live count with P=0 after a start write at edge w1
    function automatic logic [31:0] run_cnt(input logic [31:0] l, input int w1, input int c);
        return l - 32'((c - w1) / 2 - 1);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, e;
        int w, w1, w2, c, t1;

        // R1 reset state
        do_reset();
        rd(A_CTRL, d, c); check(d == 0, "R1 ctrl", d, 0);
        rd(A_CNT, d, c);  check(d == 0, "R1 count", d, 0);
        check(irq == 0, "R1 irq", irq, 0);

        // R6 auto-reload period with L=3, P=0
        do_reset();
        wr(A_LOAD, 3, w);
        wr(A_CTRL, 7, w1);
        for (int n = 0; n < 4; n++) expect_irq(w1 + 2 * (5 + 4 * n), "R6 periodic irq");
        rd(A_CTRL, d, c); check(d == 7, "R2 ctrl readback", d, 7);
        rd(A_LOAD, d, c); check(d == 0, "R2 load reads zero", d, 0);
        wait_until(w1 + 36);
        wr(A_CTRL, 1, w);
        repeat (20) @(negedge clk);

        // R3 prescale P=2 (divide by 8), L=2
        do_reset();
        wr(A_LOAD, 2, w);
        wr(A_CTRL, 32'h17, w1);
        for (int n = 0; n < 3; n++) expect_irq(w1 + 8 * (4 + 3 * n), "R3 prescaled irq");
        wait_until(w1 + 82);
        wr(A_CTRL, 1, w);
        repeat (30) @(negedge clk);

        // R7 one-shot L=5
        do_reset();
        wr(A_LOAD, 5, w);
        wr(A_CTRL, 3, w1);
        expect_irq(w1 + 14, "R7 one-shot irq");
        wait_until(w1 + 20);
        rd(A_CTRL, d, c); check(d == 1, "R7 run cleared", d, 1);
        rd(A_CNT, d, c);  check(d == 0, "R7 count held zero", d, 0);
        wr(A_CNT, 32'h55, w);
        rd(A_CNT, d, c);  check(d == 0, "R2 count write ignored", d, 0);
        wr(A_CTRL | 4'h1, 32'h7, w);
        rd(A_CTRL, d, c); check(d == 1, "R2 misaligned write ignored", d, 1);

        // R8 stop holds count
        do_reset();
        wr(A_LOAD, 100, w);
        wr(A_CTRL, 7, w1);
        wait_until(w1 + 20);
        wr(A_CTRL, 5, w2);
        e = run_cnt(100, w1, w2);
        rd(A_CNT, d, c); check(d == e, "R8 held count", d, e);
        repeat (10) @(negedge clk);
        rd(A_CNT, d, c); check(d == e, "R8 still held", d, e);

        // R9 clearing auto-reload while running
        do_reset();
        wr(A_LOAD, 100, w);
        wr(A_CTRL, 7, w1);
        expect_irq(w1 + 204, "R9 expiry after ar cleared");
        wait_until(w1 + 40);
        wr(A_CTRL, 3, w);
        rd(A_CNT, d, c); e = run_cnt(100, w1, c);
        check(d == e, "R9 count undisturbed", d, e);
        wait_until(w1 + 210);
        rd(A_CTRL, d, c); check(d == 1, "R9 one-shot after ar cleared", d, 1);

        // R10 clock enable off freezes
        do_reset();
        wr(A_LOAD, 100, w);
        wr(A_CTRL, 7, w1);
        wait_until(w1 + 30);
        wr(A_CTRL, 6, w2);
        e = run_cnt(100, w1, w2);
        rd(A_CNT, d, c); check(d == e, "R10 frozen count", d, e);
        repeat (12) @(negedge clk);
        rd(A_CNT, d, c); check(d == e, "R10 still frozen", d, e);

        // R11 idle load and load during run
        do_reset();
        wr(A_CTRL, 1, w1);
        wr(A_LOAD, 33, w);
        repeat (4) @(negedge clk);
        rd(A_CNT, d, c); check(d == 33, "R11 idle load copied", d, 33);
        wr(A_LOAD, 10, w);
        wr(A_CTRL, 7, w2);
        t1 = w1 + 2 * ((w2 - w1) / 2 + 1);
        wr(A_LOAD, 4, w);
        expect_irq(t1 + 22, "R11 first expiry uses old load");
        expect_irq(t1 + 32, "R11 reload uses new load");
        wait_until(t1 + 34);
        wr(A_CTRL, 1, w);
        repeat (20) @(negedge clk);

        // R12 free-running all ones
        do_reset();
        wr(A_LOAD, 32'hFFFF_FFFF, w);
        wr(A_CTRL, 7, w1);
        repeat (50) @(negedge clk);
        rd(A_CNT, d, c); e = 32'((c - w1) / 2 - 1);
        check(~d == e, "R12 elapsed ticks", ~d, e);
        repeat (17) @(negedge clk);
        rd(A_CNT, d, c); e = 32'((c - w1) / 2 - 1);
        check(~d == e, "R12 elapsed ticks later", ~d, e);

        check(exp_q.size() == 0, "R5 all expected irqs seen", exp_q.size(), 0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule